// File: doc/BRIEF.md
# Write-Only I2C Register Programmer

This block is a small I2C bus master that can only write. It loads the configuration registers of an external peripheral, such as a video encoder, one register at a time. A host or a ROM-driven sequencer gives a register index and a data value and pulses a start request. The block then produces a full bus transaction on two open-drain lines: a start condition, a fixed device address byte, the index byte, the value byte and a stop condition. It never looks at the SDA line. The acknowledge slot after each byte is clocked with SDA released, and whatever the slave returns in that slot is ignored. Clock stretching is not supported.

All bus timing comes from one delay counter. Each bit is split into four equal quarters: SDA is set while SCL is low, SCL is released high for two quarters, and SCL is pulled low again. With the default reload value and a 100 MHz clock, SCL runs at about 100 kHz. The `busy` output stays high from the accepted request until the stop condition is complete. `done` pulses for one cycle at that point, so requests can be queued back to back.

Top module: `i2c_reg_writer`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both `scl_oe` and `sda_oe` are 0, so both lines are released high.
- R2: A `start` pulse sampled while idle is accepted, and `busy` is 1 in the following cycle.
- R3: Before the start condition, both lines stay released for two full delay periods (2 × DELAY_CYC clock cycles) after the request is accepted.
- R4: In the start condition, SDA is pulled low while SCL is released. SCL is pulled low exactly DELAY_CYC cycles later.
- R5: Between start and stop there are exactly 27 SCL pulses. They carry the device address byte (parameter DEV_ADDR, default 8'h00), then `reg_idx`, then `reg_val`. Each byte is sent MSB first and is followed by a ninth bit with SDA released (1). The acknowledge is never sampled.
- R6: While data bits are sent, SDA changes only while SCL is low. Each transaction therefore shows exactly one start condition and one stop condition.
- R7: In every data bit, SCL stays released for exactly 2 × DELAY_CYC cycles (two quarter periods).
- R8: In the stop condition, SDA is pulled low while SCL is low, then SCL is released, then SDA is released exactly DELAY_CYC cycles after SCL.
- R9: `done` is high for exactly one cycle per transaction, in the same cycle in which `busy` returns to 0.
- R10: A `start` request that arrives while `busy` is 1 is ignored. The transaction in progress puts its original bytes on the bus, and only one `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse that starts one register write |
| reg_idx | input | 8 | Register index, captured when the request is accepted |
| reg_val | input | 8 | Register value, captured when the request is accepted |
| busy | output | 1 | High while a transaction is in progress |
| done | output | 1 | One-cycle pulse when the stop condition completes |
| scl_oe | output | 1 | 1 pulls SCL low; 0 releases it to the pull-up |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it to the pull-up |

## Verification
The in-module assertions check four things on every cycle:
- SDA stays steady while SCL is high during a data bit.
- `done` is a single-cycle pulse that coincides with the return to idle.
- `busy` rises only after a request.
- The captured frame does not change when a request arrives during a transaction.

Some behaviour can only be shown by the bench scenarios. A bus monitor in the bench decodes the two lines and checks:
- the byte contents and the released acknowledge slots;
- the quarter-period widths;
- the idle lead-in before the start condition;
- the edge order in the start and stop conditions.

// File: rtl/i2cw_pkg.sv
// Shared definitions for the write-only I2C register programmer.
// Assumes one fixed three-byte transaction format: address, index, value.
package i2cw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // lines released, waiting for a request
        ST_PRE,    // two idle delay periods before start
        ST_STA,    // SDA low, SCL high
        ST_STB,    // SCL low
        ST_BIT,    // data bits, four quarters each
        ST_SPA,    // SDA low, SCL low
        ST_SPB,    // SCL released, SDA low
        ST_SPC     // SDA released
    } wr_state_t;

    localparam int BYTE_W    = 8;
    localparam int SLOT_W    = BYTE_W + 1;
    localparam int NUM_BYTES = 3;
endpackage

// File: rtl/i2cw_quarter_timer.sv
// Quarter-period timer: while run is high, tick pulses once every DELAY_CYC
// cycles. A load restarts the count so that the first tick comes DELAY_CYC
// cycles later. Assumes DELAY_CYC >= 2.
module i2cw_quarter_timer #(
    parameter int DELAY_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic load,
    output logic tick
);
    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Down-counter that reloads at each tick or on a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
        end
    end

    assign tick = run && !load && (cnt_q == '0);

    // R7: after each tick the counter starts a full quarter again.
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == RELOAD));
endmodule

// File: rtl/i2cw_frame_shift.sv
// Frame shifter: holds the whole serial frame and presents its MSB.
// It loads on request and shifts left on each completed bit, filling with 1
// (a released line). Assumes load and shift never coincide.
module i2cw_frame_shift #(
    parameter int FRAME_BITS = 27
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  shift,
    output logic                  bit_out
);
    logic [FRAME_BITS-1:0] frame_q;

    // Frame register: load has priority over shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '1;
        end else if (load) begin
            frame_q <= frame_in;
        end else if (shift) begin
            frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
        end
    end

    assign bit_out = frame_q[FRAME_BITS-1];

    // R10: without a load or a shift, the frame keeps its contents.
    p_frame_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(frame_q));
endmodule

// File: rtl/i2c_reg_writer.sv
// Write-only I2C master. On a request it sends start, DEV_ADDR, reg_idx,
// reg_val and stop. Each byte is followed by a released acknowledge bit
// that is never sampled. SCL/SDA are open-drain: *_oe = 1 pulls the line low.
// Assumes the pull-ups are outside the block and no other master uses the bus.
module i2c_reg_writer
    import i2cw_pkg::*;
#(
    parameter int          DELAY_CYC = 250,
    parameter logic [7:0]  DEV_ADDR  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] reg_idx,
    input  logic [7:0] reg_val,
    output logic       busy,
    output logic       done,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int FRAME_BITS = NUM_BYTES * SLOT_W;
    localparam int BW         = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    wr_state_t       state_q;
    logic [1:0]      qtr_q;
    logic [BW-1:0]   bit_idx_q;
    logic            pre_q;
    logic            tick;
    logic            load;
    logic            shift;
    logic            bit_out;
    logic            scl_d;
    logic            sda_d;
    logic [FRAME_BITS-1:0] frame_in;

    assign load     = start && (state_q == ST_IDLE);
    assign busy     = (state_q != ST_IDLE);
    assign shift    = tick && (state_q == ST_BIT) && (qtr_q == 2'd3);
    assign frame_in = {DEV_ADDR, 1'b1, reg_idx, 1'b1, reg_val, 1'b1};

    i2cw_quarter_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .load  (load),
        .tick  (tick)
    );

    i2cw_frame_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .frame_in (frame_in),
        .shift    (shift),
        .bit_out  (bit_out)
    );

    // Sequencer: steps through the phases of the transaction on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            qtr_q     <= '0;
            bit_idx_q <= '0;
            pre_q     <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state_q <= ST_PRE;
                pre_q   <= 1'b0;
            end else if (tick) begin
                case (state_q)
                    ST_PRE: begin
                        if (pre_q) state_q <= ST_STA;
                        pre_q <= 1'b1;
                    end
                    ST_STA: state_q <= ST_STB;
                    ST_STB: begin
                        state_q   <= ST_BIT;
                        qtr_q     <= '0;
                        bit_idx_q <= '0;
                    end
                    ST_BIT: begin
                        qtr_q <= qtr_q + 2'd1;
                        if (qtr_q == 2'd3) begin
                            if (bit_idx_q == LAST_BIT) state_q <= ST_SPA;
                            else bit_idx_q <= bit_idx_q + 1'b1;
                        end
                    end
                    ST_SPA: state_q <= ST_SPB;
                    ST_SPB: state_q <= ST_SPC;
                    ST_SPC: begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Line decode: which line is pulled low in each phase.
    always_comb begin
        scl_d = 1'b0;
        sda_d = 1'b0;
        case (state_q)
            ST_STA: sda_d = 1'b1;
            ST_STB: begin scl_d = 1'b1; sda_d = 1'b1; end
            ST_BIT: begin
                scl_d = (qtr_q == 2'd0) || (qtr_q == 2'd3);
                sda_d = !bit_out;
            end
            ST_SPA: begin scl_d = 1'b1; sda_d = 1'b1; end
            ST_SPB: sda_d = 1'b1;
            default: ;
        endcase
    end

    // Output registers: drive the pads without glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            scl_oe <= scl_d;
            sda_oe <= sda_d;
        end
    end

    // R6: SDA stays steady in the second high quarter of a bit.
    p_sda_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT && qtr_q == 2'd2) |-> $stable(sda_d));
    // R9: done lasts one cycle only.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: done coincides with the return to idle.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R2: busy rises only after a request.
    p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R5: the bit index stays inside the frame.
    p_bit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT) |-> (bit_idx_q <= LAST_BIT));
    // R10: a request while busy does not disturb the bit being sent.
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !shift) |=> $stable(bit_out));
endmodule

// File: tb/i2c_reg_writer_bench.sv
// Directed bench: a negedge bus monitor decodes the lines; one task per scenario.
module i2c_reg_writer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int D          = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] reg_idx = '0;
    logic [7:0] reg_val = '0;
    logic       busy, done, scl_oe, sda_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    i2c_reg_writer #(.DELAY_CYC(D), .DEV_ADDR(8'h00)) u_i2c_reg_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_idx(reg_idx),
        .reg_val(reg_val), .busy(busy), .done(done),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Bus monitor state
    logic bits [0:1023];
    int nbits = 0, nstarts = 0, nstops = 0, werr = 0;
    int start_cyc = 0, rise_cyc = 0, fall_gap = 0, stop_gap = 0, ndone = 0;
    bit pscl = 1'b1, psda = 1'b1, after_start = 1'b0;

    always @(negedge clk) begin
        logic scl, sda;
        scl = !scl_oe;
        sda = !sda_oe;
        if (rst_n) begin
            if (done) ndone++;
            if (scl && pscl && psda && !sda) begin
                nstarts++; start_cyc = cyc; after_start = 1'b1;
            end
            if (scl && pscl && !psda && sda) begin
                nstops++; stop_gap = cyc - rise_cyc;
            end
            if (!pscl && scl) rise_cyc = cyc;
            if (pscl && !scl) begin
                if (after_start) begin
                    fall_gap = cyc - start_cyc; after_start = 1'b0;
                end else begin
                    if (nbits < 1024) bits[nbits] = sda;
                    nbits++;
                    if (cyc - rise_cyc != 2 * D) werr++;
                end
            end
        end
        pscl = scl;
        psda = sda;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end

    // One register write, optionally with an extra request while busy.
    task automatic do_write(input logic [7:0] ri, input logic [7:0] rv, input bit poke);
        int b0, s0, p0, d0, w0, req_cyc, got;
        logic [7:0] bytes [3];
        logic       acks  [3];
        logic [7:0] exp_b [3];
        b0 = nbits; s0 = nstarts; p0 = nstops; d0 = ndone; w0 = werr;
        exp_b[0] = 8'h00; exp_b[1] = ri; exp_b[2] = rv;
        @(negedge clk);
        start = 1'b1; reg_idx = ri; reg_val = rv; req_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after request", busy, 1);
        if (poke) begin
            repeat (2 * D + 20) @(negedge clk);
            start = 1'b1; reg_idx = ~ri; reg_val = ~rv;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        check(done == 1'b1, "R9 done with busy low", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", done, 0);
        repeat (2) @(negedge clk);
        check(ndone - d0 == 1, "R9/R10 one done per write", ndone - d0, 1);
        check(start_cyc - req_cyc >= 2 * D && start_cyc - req_cyc <= 2 * D + 3,
              "R3 idle lead-in", start_cyc - req_cyc, 2 * D + 2);
        check(fall_gap == D, "R4 SCL low after start", fall_gap, D);
        check(nstarts - s0 == 1 && nstops - p0 == 1, "R6 one start one stop",
              (nstarts - s0) * 10 + (nstops - p0), 11);
        check(stop_gap == D, "R8 SDA release after SCL", stop_gap, D);
        check(werr == w0, "R7 SCL high width", werr - w0, 0);
        check(nbits - b0 == 27, "R5 bit count", nbits - b0, 27);
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 8; j++) bytes[k][7-j] = bits[b0 + k * 9 + j];
            acks[k] = bits[b0 + k * 9 + 8];
            got = bytes[k];
            check(bytes[k] == exp_b[k], poke ? "R10 byte kept" : "R5 byte value",
                  got, exp_b[k]);
            check(acks[k] == 1'b1, "R5 released ack slot", acks[k], 1);
        end
    endtask

    task automatic test_reset();
        check(busy == 1'b0 && done == 1'b0, "R1 reset status", {busy, done}, 0);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", {scl_oe, sda_oe}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        do_write(8'h5A, 8'hC3, 1'b0);
        do_write(8'h00, 8'hFF, 1'b0);
        do_write(8'hFF, 8'h00, 1'b0);
        do_write(8'h80, 8'h01, 1'b0);
        do_write(8'h3C, 8'h96, 1'b1);   // R10: request while busy
        finish_run();
    end
endmodule